// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Controller

This block is a memory-mapped pulse-width modulation peripheral with four independent output channels. Software reaches it over a plain register bus made of a byte address, a write strobe, write data and a combinational read path. One control word holds an enable, a polarity and a drive-type bit for each channel. Each channel has its own 16-bit period and duty counts. One shared word packs a 6-bit clock divider for every channel.

A running channel divides the input clock by its divider value plus one. It counts the resulting ticks from zero up to its period, and it drives the active level while the count is below its duty. New period, duty or divider values written while a channel runs are held back until the current period ends. A disabled channel holds its counters cleared and drives the inactive level. The block itself enforces a minimum settle time between clearing an enable and the channel starting again, so a quick re-enable from software cannot restart the channel too early.

Top module: `quad_pwm`

## Requirements
- R1: After reset every mapped register reads zero and, because every polarity bit is then 0, all four outputs are high.
- R2: The control word is at byte offset 0x00. Bit c enables channel c, bit 8+c is its polarity and bit 15+c is its drive type. All other control bits read 0. The period count of channel c is at offset 0x04+8c and the duty count at 0x08+8c, each 16 bits wide with the upper 16 bits reading 0. A read of any other offset returns 0, and a write to any other offset changes nothing.
- R3: The divider word is at offset 0x24. Channel c owns bits [(3-c)*6+5 : (3-c)*6], so channel 0 sits at bits 23:18 and channel 3 at bits 5:0. Bits 31:24 read 0.
- R4: Let P be the period count, D the duty count and S the divider of a running channel. The channel's output repeats every P*(S+1) clocks and is active for the first D*(S+1) clocks of each repeat. The first active clock is the one right after the clock edge that writes the enable bit.
- R5: A polarity bit of 1 makes the active level high. A polarity bit of 0 makes the active level low.
- R6: A duty count of 0 keeps the output at its inactive level. A duty count equal to or above the period count keeps it at its active level for the whole period.
- R7: A disabled channel drives its inactive level. When it is enabled again it restarts at the beginning of a period.
- R8: After a disable, the channel does not start until SETTLE_CYC+2 clocks after the disabling write edge, even if it is enabled again sooner. It stays at the inactive level until then.
- R9: Period, duty or divider writes made while a channel runs take effect at the next period boundary. Values written while the channel is disabled apply from the first period after enable.
- R10: The drive-type bits are stored and read back but have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 6 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NCH (4) | One PWM output per channel |

## Verification
The bench sweeps channel 0 over every combination of three dividers, three periods including the minimum of 2, five duty values (zero, one, period minus one, equal to the period and beyond it) and both polarities. It compares the output on every clock against an arithmetic waveform formula. If the divider were off by one, the waveform would stretch or shrink. If the duty compare were wrong at the boundary, it would produce a glitch pulse at duty zero or a gap at full duty. If the divider fields were packed in the wrong order, the four-channel run would give each channel a neighbour's rate. A design that applied mid-run writes at once would cut the current period short. A design without the settle guard would restart the channel one clock after a fast re-enable instead of holding it idle.

// File: rtl/quad_pwm_pkg.sv
package quad_pwm_pkg;
  localparam int BUS_AW = 6;
  localparam int BUS_DW = 32;

  // register map, fixed by software compatibility
  localparam int OFS_CTRL      = 'h00;
  localparam int OFS_DIV       = 'h24;
  localparam int OFS_PER_BASE  = 'h04;
  localparam int OFS_DUTY_BASE = 'h08;
  localparam int OFS_STRIDE    = 8;

  localparam int EN_LSB  = 0;
  localparam int POL_LSB = 8;
  localparam int TYP_LSB = 15;

  // divider fields are packed with channel 0 in the highest slot
  function automatic int div_lsb(input int ch, input int nch, input int w);
    return (nch - 1 - ch) * w;
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import quad_pwm_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 16,
  parameter int PS_W  = 6
) (
  input  logic                        clk,
  input  logic                        srst_n,
  input  logic [BUS_AW-1:0]           addr,
  input  logic                        we,
  input  logic [BUS_DW-1:0]           wdata,
  output logic [BUS_DW-1:0]           rdata,
  output logic [NCH-1:0]              en_o,
  output logic [NCH-1:0]              pol_o,
  output logic [NCH-1:0][CNT_W-1:0]   per_o,
  output logic [NCH-1:0][CNT_W-1:0]   duty_o,
  output logic [NCH-1:0][PS_W-1:0]    div_o
);
  localparam int DIV_USED = NCH * PS_W;

  logic [NCH-1:0]            en_q,   en_n;
  logic [NCH-1:0]            pol_q,  pol_n;
  logic [NCH-1:0]            typ_q,  typ_n;
  logic [NCH-1:0][CNT_W-1:0] per_q,  per_n;
  logic [NCH-1:0][CNT_W-1:0] duty_q, duty_n;
  logic [NCH-1:0][PS_W-1:0]  div_q,  div_n;

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata[BUS_DW-1:DIV_USED];

  // next state: decode the write
  always_comb begin
    en_n   = en_q;
    pol_n  = pol_q;
    typ_n  = typ_q;
    per_n  = per_q;
    duty_n = duty_q;
    div_n  = div_q;
    if (we) begin
      for (int c = 0; c < NCH; c++) begin
        if (int'(addr) == OFS_CTRL) begin
          en_n[c]  = wdata[EN_LSB + c];
          pol_n[c] = wdata[POL_LSB + c];
          typ_n[c] = wdata[TYP_LSB + c];
        end
        if (int'(addr) == OFS_PER_BASE + OFS_STRIDE * c)
          per_n[c] = wdata[CNT_W-1:0];
        if (int'(addr) == OFS_DUTY_BASE + OFS_STRIDE * c)
          duty_n[c] = wdata[CNT_W-1:0];
        if (int'(addr) == OFS_DIV)
          div_n[c] = wdata[div_lsb(c, NCH, PS_W) +: PS_W];
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      en_q   <= '0;
      pol_q  <= '0;
      typ_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
      div_q  <= '0;
    end else begin
      en_q   <= en_n;
      pol_q  <= pol_n;
      typ_q  <= typ_n;
      per_q  <= per_n;
      duty_q <= duty_n;
      div_q  <= div_n;
    end
  end

  // combinational read path
  always_comb begin
    rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (int'(addr) == OFS_CTRL) begin
        rdata[EN_LSB + c]  = en_q[c];
        rdata[POL_LSB + c] = pol_q[c];
        rdata[TYP_LSB + c] = typ_q[c];
      end
      if (int'(addr) == OFS_PER_BASE + OFS_STRIDE * c)
        rdata[CNT_W-1:0] = per_q[c];
      if (int'(addr) == OFS_DUTY_BASE + OFS_STRIDE * c)
        rdata[CNT_W-1:0] = duty_q[c];
      if (int'(addr) == OFS_DIV)
        rdata[div_lsb(c, NCH, PS_W) +: PS_W] = div_q[c];
    end
  end

  assign en_o   = en_q;
  assign pol_o  = pol_q;
  assign per_o  = per_q;
  assign duty_o = duty_q;
  assign div_o  = div_q;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W      = 16,
  parameter int PS_W       = 6,
  parameter int SETTLE_CYC = 20
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             en,
  input  logic             pol,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] duty,
  input  logic [PS_W-1:0]  div,
  output logic             pwm,
  output logic             run_o
);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  logic             run_q,    run_n;
  logic [SW-1:0]    settle_q, settle_n;
  logic [PS_W-1:0]  pre_q,    pre_n;
  logic [CNT_W-1:0] cnt_q,    cnt_n;
  logic [CNT_W-1:0] sh_per_q, sh_per_n;
  logic [CNT_W-1:0] sh_dut_q, sh_dut_n;
  logic [PS_W-1:0]  sh_div_q, sh_div_n;
  logic             tick, wrap, active;

  assign tick = run_q && (pre_q == sh_div_q);
  assign wrap = tick && (({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, sh_per_q});

  always_comb begin
    // settle guard: reload on the clock the channel leaves run
    settle_n = settle_q;
    if (run_q && !en)
      settle_n = SW'(SETTLE_CYC);
    else if (settle_q != '0)
      settle_n = settle_q - 1'b1;
    run_n = en && (settle_q == '0);

    pre_n    = pre_q;
    cnt_n    = cnt_q;
    sh_per_n = sh_per_q;
    sh_dut_n = sh_dut_q;
    sh_div_n = sh_div_q;
    if (!run_q) begin
      pre_n    = '0;
      cnt_n    = '0;
      sh_per_n = per;
      sh_dut_n = duty;
      sh_div_n = div;
    end else begin
      pre_n = tick ? '0 : pre_q + 1'b1;
      if (wrap) begin
        cnt_n    = '0;
        sh_per_n = per;
        sh_dut_n = duty;
        sh_div_n = div;
      end else if (tick) begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      run_q    <= 1'b0;
      settle_q <= '0;
      pre_q    <= '0;
      cnt_q    <= '0;
      sh_per_q <= '0;
      sh_dut_q <= '0;
      sh_div_q <= '0;
    end else begin
      run_q    <= run_n;
      settle_q <= settle_n;
      pre_q    <= pre_n;
      cnt_q    <= cnt_n;
      sh_per_q <= sh_per_n;
      sh_dut_q <= sh_dut_n;
      sh_div_q <= sh_div_n;
    end
  end

  assign active = run_q && (cnt_q < sh_dut_q);
  assign pwm    = pol ? active : !active;
  assign run_o  = run_q;
endmodule

// File: rtl/quad_pwm.sv
module quad_pwm
  import quad_pwm_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int CNT_W      = 16,
  parameter int PS_W       = 6,
  parameter int SETTLE_CYC = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  logic [1:0]                rs_q;
  logic                      srst_n;
  logic [NCH-1:0]            ch_en, ch_pol, ch_run;
  logic [NCH-1:0][CNT_W-1:0] ch_per, ch_duty;
  logic [NCH-1:0][PS_W-1:0]  ch_div;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  pwm_regs #(.NCH(NCH), .CNT_W(CNT_W), .PS_W(PS_W)) u_regs (
    .clk(clk), .srst_n(srst_n),
    .addr(bus_addr), .we(bus_we), .wdata(bus_wdata), .rdata(bus_rdata),
    .en_o(ch_en), .pol_o(ch_pol), .per_o(ch_per), .duty_o(ch_duty),
    .div_o(ch_div)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_chan #(.CNT_W(CNT_W), .PS_W(PS_W), .SETTLE_CYC(SETTLE_CYC)) u_chan (
      .clk(clk), .srst_n(srst_n),
      .en(ch_en[c]), .pol(ch_pol[c]),
      .per(ch_per[c]), .duty(ch_duty[c]), .div(ch_div[c]),
      .pwm(pwm_out[c]), .run_o(ch_run[c])
    );
  end
endmodule

// File: rtl/quad_pwm_chk.sv
module quad_pwm_chk #(
  parameter int NCH        = 4,
  parameter int PS_W       = 6,
  parameter int SETTLE_CYC = 20
) (
  input logic           clk,
  input logic           rst_n,
  input logic [5:0]     bus_addr,
  input logic [31:0]    bus_rdata,
  input logic [NCH-1:0] pwm_out,
  input logic [NCH-1:0] en_q,
  input logic [NCH-1:0] pol_q,
  input logic [NCH-1:0] run_q
);
  localparam int GW      = $clog2(SETTLE_CYC + 2) + 1;
  localparam int MAP_END = 4 + 8 * NCH;
  localparam int DIV_HI  = NCH * PS_W;

  logic [NCH-1:0] en_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_d <= '0;
    else        en_d <= en_q;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(bus_addr) > MAP_END) || (bus_addr[1:0] != 2'b00)) |-> (bus_rdata == '0)); // R2

  AST_COUNT_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(bus_addr) >= 4) && (int'(bus_addr) < MAP_END) && (bus_addr[1:0] == 2'b00))
      |-> (bus_rdata[31:16] == 16'h0)); // R2

  AST_DIV_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr) == MAP_END) |-> (bus_rdata[31:DIV_HI] == '0)); // R3

  for (genvar c = 0; c < NCH; c++) begin : g_c
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      gap_q <= GW'(SETTLE_CYC);
      else if (en_d[c] && !en_q[c])    gap_q <= '0;
      else if (gap_q < GW'(SETTLE_CYC)) gap_q <= gap_q + 1'b1;
    end

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[c] && !$past(en_q[c])) |-> (pwm_out[c] == !pol_q[c])); // R7

    AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q[c]) |-> (gap_q >= GW'(SETTLE_CYC))); // R8
  end
endmodule

bind quad_pwm quad_pwm_chk #(.NCH(NCH), .PS_W(PS_W), .SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .pwm_out(pwm_out), .en_q(ch_en), .pol_q(ch_pol), .run_q(ch_run)
);

// File: tb/sim_quad_pwm.sv
`timescale 1ns/1ps
module sim_quad_pwm;
  localparam int S = 20;

  logic        clk;
  logic        rst_n;
  logic [5:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int tests = 0;
  int fails = 0;

  quad_pwm #(.NCH(4), .CNT_W(16), .PS_W(6), .SETTLE_CYC(S)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_addr  = 6'(a);
    bus_wdata = d;
    bus_we    = 1'b1;
    tick();
    bus_we    = 1'b0;
  endtask

  task automatic rd(input string tag, input int a, input logic [31:0] exp);
    bus_addr = 6'(a);
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  // expected output level from the waveform rule
  function automatic logic lvl(input int k, input int p, input int d, input int ps, input logic pol);
    logic a;
    a = ((k / (ps + 1)) % p) < d;
    return pol ? a : !a;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int plist[3] = '{2, 3, 5};
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1: reset state
    chk("R1 outputs after reset", 32'(pwm_out), 32'hF);
    for (int a = 0; a <= 'h24; a += 4) rd($sformatf("R1 reset read %h", a), a, 0);

    // R2 / R10: register map and type bits
    wr('h00, 32'h0007_8000);
    rd("R10 type readback", 'h00, 32'h0007_8000);
    tick();
    chk("R10 type bits no effect", 32'(pwm_out), 32'hF);
    wr('h00, 32'hFFFF_FFFF);
    rd("R2 ctrl readback", 'h00, 32'h0007_8F0F);
    wr('h00, 32'h0);
    wr('h14, 32'hABCD_1234);
    rd("R2 period ch2", 'h14, 32'h0000_1234);
    wr('h20, 32'h5555_FFFF);
    rd("R2 duty ch3", 'h20, 32'h0000_FFFF);
    wr('h28, 32'hFFFF_FFFF);
    rd("R2 unmapped 0x28", 'h28, 0);
    rd("R2 unmapped 0x05", 'h05, 0);
    rd("R2 period ch2 kept", 'h14, 32'h0000_1234);
    wr('h24, 32'hFFFF_FFFF);
    rd("R3 divider width", 'h24, 32'h00FF_FFFF);
    wr('h24, 32'(3) << 18);
    rd("R3 ch0 field position", 'h24, 32'h000C_0000);
    wr('h24, 0);

    // R4/R5/R6/R9/R10: sweep on channel 0
    for (int pol = 0; pol < 2; pol++)
      for (int ps = 0; ps < 3; ps++)
        for (int pi = 0; pi < 3; pi++)
          for (int di = 0; di < 5; di++) begin
            int p = plist[pi];
            int d;
            int typ = di % 2;
            string tag;
            case (di)
              0: d = 0;
              1: d = 1;
              2: d = p - 1;
              3: d = p;
              default: d = p + 2;
            endcase
            tag = (d == 0 || d >= p) ? "R6" : (pol == 0 ? "R5" : "R4");
            wr('h00, 32'(pol) << 8);
            wr('h04, 32'(p));
            wr('h08, 32'(d));
            wr('h24, 32'(ps) << 18);
            repeat (S) tick();
            chk("R7 disabled level", 32'(pwm_out[0]), 32'(!pol));
            wr('h00, 32'h1 | (32'(pol) << 8) | (32'(typ) << 15));
            for (int k = 0; k < 2 * p * (ps + 1) + 2; k++) begin
              tick();
              chk($sformatf("%s R9 p=%0d d=%0d ps=%0d pol=%0d k=%0d", tag, p, d, ps, pol, k),
                  32'(pwm_out[0]), 32'(lvl(k, p, d, ps, pol[0])));
            end
          end

    // R8 / R7: fast re-enable is held off, then restarts from period start
    wr('h00, 32'h100);
    wr('h04, 4); wr('h08, 2); wr('h24, 0);
    repeat (S) tick();
    wr('h00, 32'h101);
    repeat (7) tick();
    wr('h00, 32'h100);
    wr('h00, 32'h101);
    for (int j = 0; j < S; j++) begin
      tick();
      chk($sformatf("R8 held idle j=%0d", j), 32'(pwm_out[0]), 0);
    end
    for (int k = 0; k < 12; k++) begin
      tick();
      chk($sformatf("R7 restart k=%0d", k), 32'(pwm_out[0]), 32'(lvl(k, 4, 2, 0, 1'b1)));
    end

    // R9: mid-run writes wait for the period boundary
    wr('h00, 32'h100);
    wr('h04, 3); wr('h08, 1); wr('h24, 32'(1) << 18);
    repeat (S) tick();
    wr('h00, 32'h101);
    for (int k = 0; k < 26; k++) begin
      tick();
      chk($sformatf("R9 boundary update k=%0d", k), 32'(pwm_out[0]),
          32'(k < 6 ? lvl(k, 3, 1, 1, 1'b1) : lvl(k - 6, 5, 4, 0, 1'b1)));
      if (k == 2) begin bus_addr = 6'h04; bus_wdata = 5; bus_we = 1'b1; end
      if (k == 3) begin bus_addr = 6'h08; bus_wdata = 4; end
      if (k == 4) begin bus_addr = 6'h24; bus_wdata = 0; end
      if (k == 5) bus_we = 1'b0;
    end

    // R3 / R4: all channels at once, each with its own divider field
    wr('h00, 32'hF00);
    begin
      logic [31:0] dw = 0;
      for (int c = 0; c < 4; c++) begin
        wr(4 + 8 * c, 32'(3 + c));
        wr(8 + 8 * c, 32'(c + 1));
        dw = dw | (32'(c) << ((3 - c) * 6));
      end
      wr('h24, dw);
    end
    repeat (S) tick();
    wr('h00, 32'hF0F);
    for (int k = 0; k < 60; k++) begin
      tick();
      for (int c = 0; c < 4; c++)
        chk($sformatf("R3 R4 ch=%0d k=%0d", c, k), 32'(pwm_out[c]),
            32'(lvl(k, 3 + c, c + 1, c, 1'b1)));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule